// File: doc/BRIEF.md
# Wilkinson ADC Gray Conversion Controller

This block holds the digital sequencing and counting for a two-channel ramp-compare (Wilkinson) converter of the kind used to read out CCD signals. A start pulse runs one conversion. First the integrator gate is driven for a programmed number of cycles. The hold output then goes high for a second programmed number of cycles. After that the ramp gate opens, and a single 12-bit run-up counter advances in Gray code on every clock. The counter is meant to run at 167 MHz in the target system.

Each channel has its own comparator input, passed through a two-flop synchronizer. The first time a channel's synchronized comparator reads high during the ramp, that channel stores the current Gray count. If a channel never trips before the count reaches full scale, it stores full scale and raises an overrange flag. The stored codes are converted to binary only at the output. A select input can present the raw Gray codes instead. The block does no correlated double subtraction: every sample leaves as a raw code, so that the subtraction can be done downstream.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: While reset is asserted and just after it, all gate outputs, `valid`, both results and both overrange flags are 0.
- R2: A `start` sampled high in the idle state drives `int_gate` high starting on the next cycle, for max(`int_len`,1) consecutive cycles.
- R3: After the integrate phase, `hold_on` is high for max(`hold_len`,1) cycles with `ramp_gate` low. `ramp_gate` then rises, and `hold_on` stays high through the ramp. `int_gate` is never high together with `hold_on` or `ramp_gate`.
- R4: The run-up count is 0 in the first ramp cycle and rises by 1 each cycle. A comparator input passes two synchronizer flops, so a level first driven high during ramp cycle j is seen in ramp cycle j+2. A comparator that is already high two cycles before the ramp gives code 0.
- R5: Each channel latches on its own comparator, only once per conversion, at the first ramp cycle in which its synchronized comparator is high. Later changes on that comparator have no effect on the result.
- R6: A channel with no comparator trip by count 4095 gets result 4095 and its overrange flag set to 1. A trip exactly at count 4095 gives 4095 with the flag at 0.
- R7: The ramp lasts L+1 cycles, where L is the larger of the two latched counts. It is followed by one cycle with `valid` high and `ramp_gate` low, and then the idle state.
- R8: Results and overrange flags keep their values from the valid cycle until the next conversion's ramp begins.
- R9: With `raw_sel` at 0 the results are binary. With `raw_sel` at 1 they are the Gray codes g = b XOR (b >> 1).
- R10: A `start` pulse received while a conversion is in progress is ignored. No integrate phase follows the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a conversion when the block is idle |
| cmp_a | input | 1 | Ramp comparator, channel A (asynchronous) |
| cmp_b | input | 1 | Ramp comparator, channel B (asynchronous) |
| raw_sel | input | 1 | 1 selects raw Gray output, 0 selects binary |
| int_len | input | 8 | Integrate length in cycles (0 is treated as 1) |
| hold_len | input | 8 | Hold length in cycles (0 is treated as 1) |
| int_gate | output | 1 | Integrator gate |
| hold_on | output | 1 | Hold control, high in hold and in the ramp |
| ramp_gate | output | 1 | Ramp gate; also marks the counting window |
| valid | output | 1 | One-cycle pulse when both results are final |
| res_a | output | 12 | Channel A result |
| res_b | output | 12 | Channel B result |
| ovr_a | output | 1 | Channel A overrange |
| ovr_b | output | 1 | Channel B overrange |

## Verification
A phase timer that is off by one shows up as a wrong count of `int_gate` or `hold_on` cycles, and the error is visible in the conversion where it happens. A counter or synchronizer that is wrong shifts both results by a fixed offset, and this is seen at the first `valid` pulse. A latch flag that fails to stick makes the result follow later comparator edges. It also shows as a ramp that is longer than the larger latched count plus one. A flawed exit condition shows as a missing or doubled `valid` pulse, or as an integrate phase that nobody requested after a start pulse sent mid-conversion.

// File: rtl/wilk_conv_ctrl.sv
module wilk_conv_ctrl #(
  parameter int NB = 12,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp_a,
  input  logic          cmp_b,
  input  logic          raw_sel,
  input  logic [TW-1:0] int_len,
  input  logic [TW-1:0] hold_len,
  output logic          int_gate,
  output logic          hold_on,
  output logic          ramp_gate,
  output logic          valid,
  output logic [NB-1:0] res_a,
  output logic [NB-1:0] res_b,
  output logic          ovr_a,
  output logic          ovr_b
);
  typedef enum logic [2:0] {S_IDLE, S_INT, S_HOLD, S_RAMP, S_DONE} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [NB-1:0] bcnt, ga, gb;
  logic [1:0]    sa, sb;
  logic          la, lb, oa, ob;

  function automatic logic [NB-1:0] g2b(input logic [NB-1:0] g);
    logic [NB-1:0] b;
    b[NB-1] = g[NB-1];
    for (int i = NB - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  wire [NB-1:0] gray_now = bcnt ^ (bcnt >> 1);
  wire          at_max   = &bcnt;
  wire          in_ramp  = (st == S_RAMP);
  wire          take_a   = in_ramp && !la && (sa[1] || at_max);
  wire          take_b   = in_ramp && !lb && (sb[1] || at_max);
  wire [TW-1:0] len_sel  = (st == S_HOLD) ? hold_len : int_len;
  wire [TW:0]   tmr_nx   = {1'b0, tmr} + (TW+1)'(1);
  wire          tmr_end  = tmr_nx >= {1'b0, len_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa <= '0;
      sb <= '0;
    end else begin
      sa <= {sa[0], cmp_a};
      sb <= {sb[0], cmp_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tmr  <= '0;
      bcnt <= '0;
      ga   <= '0;
      gb   <= '0;
      la   <= 1'b0;
      lb   <= 1'b0;
      oa   <= 1'b0;
      ob   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st  <= S_INT;
          tmr <= '0;
        end
        S_INT: if (tmr_end) begin
          st  <= S_HOLD;
          tmr <= '0;
        end else tmr <= tmr + TW'(1);
        S_HOLD: if (tmr_end) begin
          st   <= S_RAMP;
          bcnt <= '0;
          la   <= 1'b0;
          lb   <= 1'b0;
          oa   <= 1'b0;
          ob   <= 1'b0;
        end else tmr <= tmr + TW'(1);
        S_RAMP: begin
          bcnt <= bcnt + NB'(1);
          if (take_a) begin
            ga <= gray_now;
            la <= 1'b1;
            oa <= !sa[1];
          end
          if (take_b) begin
            gb <= gray_now;
            lb <= 1'b1;
            ob <= !sb[1];
          end
          if ((la || take_a) && (lb || take_b)) st <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign int_gate  = (st == S_INT);
  assign hold_on   = (st == S_HOLD) || in_ramp;
  assign ramp_gate = in_ramp;
  assign valid     = (st == S_DONE);
  assign res_a     = raw_sel ? ga : g2b(ga);
  assign res_b     = raw_sel ? gb : g2b(gb);
  assign ovr_a     = oa;
  assign ovr_b     = ob;
endmodule

module wilk_conv_ctrl_chk #(
  parameter int NB = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          raw_sel,
  input logic          int_gate,
  input logic          hold_on,
  input logic          ramp_gate,
  input logic          valid,
  input logic [NB-1:0] res_a,
  input logic [NB-1:0] res_b,
  input logic          ovr_a,
  input logic          ovr_b
);
  p_gates_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_gate |-> !(hold_on || ramp_gate));
  p_ramp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_gate |-> hold_on);
  p_int_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_gate) |-> $past(start));
  p_valid_after_ramp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($past(ramp_gate) && !ramp_gate));
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !int_gate);
  p_hold_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_gate && $past(!ramp_gate) && $stable(raw_sel)) |->
      ($stable(res_a) && $stable(res_b) && $stable(ovr_a) && $stable(ovr_b)));
  p_ovr_full_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_a && !raw_sel) |-> (&res_a));
  p_ovr_full_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_b && !raw_sel) |-> (&res_b));
endmodule

bind wilk_conv_ctrl wilk_conv_ctrl_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .raw_sel(raw_sel),
  .int_gate(int_gate), .hold_on(hold_on), .ramp_gate(ramp_gate),
  .valid(valid), .res_a(res_a), .res_b(res_b), .ovr_a(ovr_a), .ovr_b(ovr_b)
);

// File: tb/wilk_conv_ctrl_test.sv
`timescale 1ns/1ps
module wilk_conv_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp_a = 1'b0, cmp_b = 1'b0, raw_sel = 1'b0;
  logic [7:0] int_len = '0, hold_len = '0;
  logic int_gate, hold_on, ramp_gate, valid, ovr_a, ovr_b;
  logic [11:0] res_a, res_b;
  int tests = 0, fails = 0;
  localparam int NEVER = 100000;

  always #2 clk = ~clk;

  wilk_conv_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .raw_sel(raw_sel), .int_len(int_len), .hold_len(hold_len),
    .int_gate(int_gate), .hold_on(hold_on), .ramp_gate(ramp_gate), .valid(valid),
    .res_a(res_a), .res_b(res_b), .ovr_a(ovr_a), .ovr_b(ovr_b)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int plen(int l); return (l < 1) ? 1 : l; endfunction
  function automatic int raw_code(int j); return (j < 0) ? 0 : j + 2; endfunction
  function automatic int clip(int c); return (c > 4095) ? 4095 : c; endfunction
  function automatic int gray(int b); return b ^ (b >> 1); endfunction

  task automatic run_conv(int il, int hl, int ja, int jb, bit poke);
    int n, j, ca, cb, ea, eb;
    ca = raw_code(ja); cb = raw_code(jb);
    ea = clip(ca);     eb = clip(cb);
    int_len = 8'(il); hold_len = 8'(hl);
    cmp_a = (ja < 0); cmp_b = (jb < 0);
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (int_gate) begin n++; @(negedge clk); end
    chk("R2 integrate length", n, plen(il));
    n = 0;
    while (hold_on && !ramp_gate) begin n++; @(negedge clk); end
    chk("R3 hold length", n, plen(hl));
    j = 0;
    while (!valid && ramp_gate) begin
      if (j == ja) cmp_a = 1'b1;
      if (j == jb) cmp_b = 1'b1;
      start = (poke && j == 5);
      if (!hold_on) chk("R3 hold during ramp", 0, 1);
      j++;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R7 ramp length", j, ((ea > eb) ? ea : eb) + 1);
    chk("R7 valid after ramp", int'(valid), 1);
    raw_sel = 1'b0; #0.1;
    chk("R4 R5 result a", int'(res_a), ea);
    chk("R4 R5 result b", int'(res_b), eb);
    chk("R6 overrange a", int'(ovr_a), int'(ca > 4095));
    chk("R6 overrange b", int'(ovr_b), int'(cb > 4095));
    raw_sel = 1'b1; #0.1;
    chk("R9 gray a", int'(res_a), gray(ea));
    chk("R9 gray b", int'(res_b), gray(eb));
    raw_sel = 1'b0;
    @(negedge clk);
    chk("R7 valid one cycle", int'(valid), 0);
    cmp_a = 1'b0; cmp_b = 1'b0;
    repeat (3) begin
      chk("R10 no restart", int'(int_gate), 0);
      @(negedge clk);
    end
    chk("R8 result a held", int'(res_a), ea);
    chk("R8 result b held", int'(res_b), eb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'd2024);
    repeat (2) @(negedge clk);
    chk("R1 reset gates", int'({int_gate, hold_on, ramp_gate, valid}), 0);
    chk("R1 reset results", int'({res_a, res_b, ovr_a, ovr_b}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", int'({int_gate, hold_on, ramp_gate, valid, res_a, res_b}), 0);
    run_conv(0, 0, -1, 10, 1'b0);
    run_conv(5, 3, NEVER, NEVER, 1'b1);
    run_conv(1, 1, 4093, 4094, 1'b0);
    run_conv(255, 2, 40, -1, 1'b1);
    run_conv(3, 4, 7, 7, 1'b0);
    for (int k = 0; k < 20; k++) begin
      run_conv(int'($urandom % 40), int'($urandom % 40),
               int'($urandom % 700) - 1, int'($urandom % 700) - 1, bit'($urandom % 2));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule